// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a small bus master helper for a two-wire serial bus. Once the host has issued the STOP that ends a write to a nonvolatile memory slave, it pulses `go`. From then on the poller probes the slave over and over. Each probe is a START condition followed by the slave address byte. A slave that is still busy with its internal write cycle does not acknowledge its address. The poller then issues a STOP and tries again at once. When an acknowledge comes back, the poller stops and raises `ready`. It leaves the bus open, with SCL held low and SDA released, so the next read or write can go on with no new address phase.

A fixed worst-case wait is not used. The slave's missing acknowledge serves as its busy flag, so the poller finishes as soon as the write actually completes. A limit on the number of attempts ends a run with `timeout` if the slave never answers. The attempt count is reported on `tries`.

SCL is made from the system clock. Every bus bit lasts four quarters, and each quarter lasts `DIV` system cycles. SDA is open-drain: `sda_oe` high pulls the line low, and `sda_oe` low releases it to the pull-up. All pins are plain control and status pins, and there is no streaming interface.

Top module: `ackpoll_top`

## Requirements
- R1: After reset and before any `go`, `scl` is 1, `sda_oe` is 0, `ready` and `timeout` are 0, and `tries` is 0.
- R2: Each attempt is a START (SDA falls while SCL is high) followed by eight bits sampled on the SCL rising edges, MSB first. The eight bits are `{dev_addr[6:0], rd_dir}`, latched when `go` is accepted. A 0 bit is sent as `sda_oe`=1, and a 1 bit as `sda_oe`=0.
- R3: While SCL stays high, `sda_oe` changes only inside a START or STOP condition.
- R4: If SDA reads 1 at the ninth SCL high phase (no acknowledge), the poller emits a STOP (SDA rises while SCL is high) and begins the next attempt right away, unless the attempt limit has been reached.
- R5: If SDA reads 0 at the ninth SCL high phase, no STOP is sent. `ready` goes to 1, with `scl`=0 and `sda_oe`=0, and stays so until the next `go`.
- R6: `tries` equals the number of STARTs issued since the last accepted `go`.
- R7: After `MAX_TRIES` attempts without an acknowledge and the STOP of the last one, `timeout` goes to 1, `tries` equals `MAX_TRIES`, and the bus is left idle (`scl`=1, `sda_oe`=0).
- R8: Polling starts with no delay. If `go` is sampled at edge E, `ready` is first seen after edge E+(40+44·k)·DIV, where k is the number of attempts that were not acknowledged.
- R9: `go` is accepted only while idle, done or timed out. A `go` during an active poll has no effect on `tries`, timing or the address sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | One-cycle request to start polling |
| dev_addr | input | 7 | Slave address sent in each probe |
| rd_dir | input | 1 | Direction bit appended to the address |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl | output | 1 | Serial clock level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ready | output | 1 | Slave acknowledged; bus held open |
| timeout | output | 1 | Attempt limit reached without acknowledge |
| tries | output | TRY_W = clog2(MAX_TRIES+1) | Attempts made in the current or last run |

## Verification
The bench attaches a model slave that refuses a set number of probes before it acknowledges. The main function is driven with 0, 1, 3, MAX_TRIES-1 and more than MAX_TRIES refusals. These runs tell first-probe success, short and long retry chains, the last allowed attempt, and the timeout apart. Address patterns change between runs and include both direction bits, which exposes bit-order and latch errors. Each run compares the completion cycle, the START and STOP counts seen on the wire, and the received byte. A stray `go` in the middle of a run shows whether the request was wrongly restarted.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_START,
    PS_ADDR,
    PS_ACK,
    PS_STOP,
    PS_DONE,
    PS_FAIL
  } poll_st_e;
endpackage

// File: rtl/ackpoll_tick.sv
// Quarter-bit strobe: one pulse every DIV cycles while the bus is active.
module ackpoll_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!run || cnt == LAST) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/ackpoll_seq.sv
// Attempt sequencer: START, 8 address bits, ACK slot, then STOP/retry or done.
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int MAX_TRIES = 8,
  parameter int TRY_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic             sda_i,
  output poll_st_e         st,
  output logic [1:0]       q,
  output logic [2:0]       bi,
  output logic [TRY_W-1:0] tries,
  output logic             accept,
  output logic             run
);
  localparam logic [TRY_W-1:0] LIMIT = TRY_W'(MAX_TRIES);
  logic ack_seen;

  assign accept = go && (st == PS_IDLE || st == PS_DONE || st == PS_FAIL);
  assign run    = (st == PS_START) || (st == PS_ADDR) ||
                  (st == PS_ACK)   || (st == PS_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PS_IDLE;
      q        <= '0;
      bi       <= '0;
      tries    <= '0;
      ack_seen <= 1'b0;
    end else if (accept) begin
      st       <= PS_START;
      q        <= '0;
      bi       <= '0;
      tries    <= TRY_W'(1);
      ack_seen <= 1'b0;
    end else if (tick) begin
      q <= q + 2'd1;
      // sample the acknowledge in the middle of the ninth high phase
      if (st == PS_ACK && q == 2'd2) ack_seen <= !sda_i;
      if (q == 2'd3) begin
        unique case (st)
          PS_START: begin
            st <= PS_ADDR;
            bi <= '0;
          end
          PS_ADDR: begin
            if (bi == 3'd7) st <= PS_ACK;
            else            bi <= bi + 3'd1;
          end
          PS_ACK:   st <= ack_seen ? PS_DONE : PS_STOP;
          PS_STOP: begin
            if (tries == LIMIT) begin
              st <= PS_FAIL;
            end else begin
              st    <= PS_START;
              tries <= tries + 1'b1;
            end
          end
          default:  st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/ackpoll_drive.sv
// Decodes sequencer position into SCL level and SDA pull-down.
// SDA is updated one quarter after SCL falls, so data never moves on an SCL edge.
module ackpoll_drive
  import ackpoll_pkg::*;
(
  input  poll_st_e   st,
  input  logic [1:0] q,
  input  logic [2:0] bi,
  input  logic [7:0] abyte,
  output logic       scl,
  output logic       sda_oe,
  output logic       in_cond
);
  logic [2:0] cur_idx;
  logic [2:0] prev_idx;
  logic       bitval;

  assign cur_idx  = 3'd7 - bi;
  assign prev_idx = cur_idx + 3'd1;

  always_comb begin
    if (q == 2'd0) bitval = (bi == 3'd0) ? 1'b0 : abyte[prev_idx];
    else           bitval = abyte[cur_idx];
  end

  assign in_cond = (st == PS_START) || (st == PS_STOP);

  always_comb begin
    scl    = 1'b1;
    sda_oe = 1'b0;
    unique case (st)
      PS_START: begin
        scl    = (q != 2'd3);
        sda_oe = q[1];
      end
      PS_ADDR: begin
        scl    = q[1];
        sda_oe = !bitval;
      end
      PS_ACK: begin
        scl    = q[1];
        sda_oe = (q == 2'd0) ? !abyte[0] : 1'b0;
      end
      PS_STOP: begin
        scl    = q[1];
        sda_oe = (q == 2'd1) || (q == 2'd2);
      end
      PS_DONE: begin
        scl    = 1'b0;
        sda_oe = 1'b0;
      end
      default: begin
        scl    = 1'b1;
        sda_oe = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ackpoll_top.sv
module ackpoll_top
  import ackpoll_pkg::*;
#(
  parameter  int DIV       = 4,
  parameter  int MAX_TRIES = 8,
  localparam int TRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [6:0]       dev_addr,
  input  logic             rd_dir,
  input  logic             sda_i,
  output logic             scl,
  output logic             sda_oe,
  output logic             ready,
  output logic             timeout,
  output logic [TRY_W-1:0] tries
);
  poll_st_e   st;
  logic [1:0] q;
  logic [2:0] bi;
  logic       accept;
  logic       run;
  logic       tick;
  logic       in_cond;
  logic [7:0] abyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      abyte <= '0;
    else if (accept) abyte <= {dev_addr, rd_dir};
  end

  ackpoll_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  ackpoll_seq #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .tick  (tick),
    .sda_i (sda_i),
    .st    (st),
    .q     (q),
    .bi    (bi),
    .tries (tries),
    .accept(accept),
    .run   (run)
  );

  ackpoll_drive u_drive (
    .st     (st),
    .q      (q),
    .bi     (bi),
    .abyte  (abyte),
    .scl    (scl),
    .sda_oe (sda_oe),
    .in_cond(in_cond)
  );

  assign ready   = (st == PS_DONE);
  assign timeout = (st == PS_FAIL);
endmodule

// File: rtl/ackpoll_chk.sv
module ackpoll_chk #(
  parameter int MAX_TRIES = 8,
  parameter int TRY_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl,
  input logic             sda_oe,
  input logic             sda_i,
  input logic             in_cond,
  input logic             ready,
  input logic             timeout,
  input logic [TRY_W-1:0] tries
);
  // R3
  sda_steady_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl) && !$stable(sda_oe)) |-> in_cond);

  // R5
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !$past(sda_i));

  // R5
  ready_bus_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!scl && !sda_oe));

  // R7
  timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (tries == TRY_W'(MAX_TRIES)));

  // R7
  timeout_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (scl && !sda_oe));

  // R6
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_W'(MAX_TRIES));

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && timeout));
endmodule

bind ackpoll_top ackpoll_chk #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl    (scl),
  .sda_oe (sda_oe),
  .sda_i  (sda_i),
  .in_cond(in_cond),
  .ready  (ready),
  .timeout(timeout),
  .tries  (tries)
);

// File: tb/sim_ackpoll_top.sv
`timescale 1ns/1ps
module sim_ackpoll_top;
  localparam int DIV   = 2;
  localparam int MAXT  = 5;
  localparam int TW    = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [6:0] dev_addr = '0;
  logic rd_dir = 1'b0;
  logic scl, sda_oe, ready, timeout;
  logic [TW-1:0] tries;

  logic slave_pull = 1'b0;
  wire  sda_line = !(sda_oe || slave_pull);

  always #2.5 clk = ~clk;

  ackpoll_top #(.DIV(DIV), .MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr), .rd_dir(rd_dir),
    .sda_i(sda_line), .scl(scl), .sda_oe(sda_oe), .ready(ready),
    .timeout(timeout), .tries(tries)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  int nack_left = 0;
  int n_start = 0;
  int n_stop = 0;
  int bitcnt = 0;
  logic in_frame = 1'b0;
  logic [7:0] rx = '0;
  logic [7:0] last_rx = '0;

  always @(negedge sda_line) if (scl === 1'b1) begin
    n_start++; in_frame = 1'b1; bitcnt = 0;
  end
  always @(posedge sda_line) if (scl === 1'b1) begin
    n_stop++; in_frame = 1'b0;
  end
  always @(posedge scl) if (in_frame && bitcnt < 8) begin
    rx = {rx[6:0], sda_line}; bitcnt++;
  end
  always @(negedge scl) begin
    if (slave_pull) slave_pull = 1'b0;
    else if (in_frame && bitcnt == 8) begin
      bitcnt = 9;
      last_rx = rx;
      if (nack_left > 0) nack_left--;
      else slave_pull = 1'b1;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    string tag;
    int    tries;
    bit    to;
    logic [7:0] byt;
    int    cycles;   // -1: not checked
    int    start0;
    int    stop0;
    int    c0;
  } exp_t;
  exp_t sb[$];

  task automatic run_poll(input string tag, input logic [6:0] a, input logic rd,
                          input int nacks, input bit stray_go);
    exp_t e;
    @(negedge clk);
    nack_left = nacks;
    dev_addr  = a;
    rd_dir    = rd;
    e.tag    = tag;
    e.to     = (nacks >= MAXT);
    e.tries  = e.to ? MAXT : nacks + 1;
    e.byt    = {a, rd};
    e.cycles = e.to ? -1 : 1 + (40 + 44 * nacks) * DIV;
    e.start0 = n_start;
    e.stop0  = n_stop;
    e.c0     = cyc;
    sb.push_back(e);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    dev_addr = ~a;
    rd_dir   = ~rd;
    if (stray_go) begin
      repeat (30) @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  logic fin_q = 1'b0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if ((ready || timeout) && !fin_q && sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        // R6 attempts counted
        chk({e.tag, " R6 tries"}, int'(tries), e.tries);
        // R7 / R5 outcome
        chk({e.tag, " R7 timeout"}, int'(timeout), int'(e.to));
        chk({e.tag, " R5 ready"}, int'(ready), int'(!e.to));
        // R2 address byte on the wire, MSB first
        chk({e.tag, " R2 byte"}, int'(last_rx), int'(e.byt));
        // R3/R6 one START per attempt, no stray SDA edges while SCL high
        chk({e.tag, " R3 starts"}, n_start - e.start0, e.tries);
        // R4/R5 STOP after each refusal, none after acknowledge
        chk({e.tag, " R4 stops"}, n_stop - e.stop0, e.to ? e.tries : e.tries - 1);
        // R8 R9 completion cycle
        if (e.cycles >= 0) chk({e.tag, " R8 cycles"}, cyc - e.c0, e.cycles);
        if (e.to) begin
          chk({e.tag, " R7 scl idle"}, int'(scl), 1);
          chk({e.tag, " R7 sda idle"}, int'(sda_oe), 0);
        end
      end
      fin_q = ready || timeout;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl", int'(scl), 1);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 ready", int'(ready), 0);
    chk("R1 timeout", int'(timeout), 0);
    chk("R1 tries", int'(tries), 0);

    run_poll("first", 7'h50, 1'b0, 0, 1'b0);
    // R5 bus stays open until next go
    repeat (12) @(negedge clk);
    chk("R5 hold ready", int'(ready), 1);
    chk("R5 hold scl", int'(scl), 0);
    chk("R5 hold sda", int'(sda_oe), 0);

    run_poll("three", 7'h2B, 1'b1, 3, 1'b0);
    run_poll("last_ok", 7'h7F, 1'b0, MAXT - 1, 1'b0);
    run_poll("expire", 7'h01, 1'b1, 9, 1'b0);
    run_poll("stray", 7'h55, 1'b1, 1, 1'b1);   // R9
    run_poll("again", 7'h00, 1'b0, 0, 1'b0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule